// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filtering

This block takes an asynchronous serial line and turns each eleven-bit frame into a data byte plus a ninth bit. A frame is a low start bit, eight data bits sent least significant first, a ninth bit, and a stop bit. The line is first passed through a synchronizer. It is then examined only on cycles where an external enable pulses, and that enable runs at sixteen times the bit rate. Each bit is settled by a two-of-three vote taken around the middle of its bit time.

A nine-bit shift register is filled with ones when a start edge is seen. The start bit is a zero, and it moves towards the top of the register as bits arrive. When it reaches the top, the next shift is the last shift of the frame. At that last shift the frame is handed over only if two things hold: the receive-complete flag is clear, and either filtering is off or the ninth bit is one. A frame that fails this test is dropped whole. Software-side logic reads the outputs and then clears the flag with a pulse. Setting filtering mode lets a node ignore data frames and listen only for address frames, whose ninth bit is one.

Top module: `nine_bit_rx`

## Requirements
- R1: After reset, rx_byte is 0, rx_bit9 is 0, rx_done is 0, and the receiver is waiting for a start edge.
- R2: Reception begins when the synchronized line is sampled high on one enabled cycle and low on the next enabled cycle. All bit timing counts enabled cycles only, with sixteen of them per bit.
- R3: Each bit takes the value seen in at least two of three samples, taken at counts 7, 8 and 9 of its bit time. A disturbance that covers a single sample does not change the received value.
- R4: If the vote for the start bit is 1, the frame is abandoned, the outputs are left unchanged, and the receiver waits for a new start edge.
- R5: An accepted frame puts data bit k (the k-th bit after the start bit, counting from 0) on rx_byte[k] and the tenth bit of the frame on rx_bit9, and it sets rx_done.
- R6: When filter_en is 1, a frame whose ninth bit is 0 is discarded, and rx_byte, rx_bit9 and rx_done are left unchanged.
- R7: A frame that completes while rx_done is 1 is discarded, and rx_byte and rx_bit9 keep their earlier values.
- R8: rx_done stays 1 until a cycle with rx_clr high, and it is 0 on the following cycle.
- R9: The value of the stop bit does not affect the outputs. The receiver looks for a new start edge from one bit time after the last shift, so frames sent back to back with a single stop bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Enable that pulses at sixteen times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| filter_en | input | 1 | Static control: when 1, accept only frames whose ninth bit is 1 |
| rx_clr | input | 1 | Pulse that clears rx_done |
| rx_byte | output | DATA_W | Data bits of the last accepted frame |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_done | output | 1 | Receive-complete flag |

## Verification
The hardest case to reach is a single-sample disturbance that falls inside the three-sample voting window. The phase of that window depends on the synchronizer delay and on where the start edge falls among the enable pulses. To reach it, the stimulus inverts the line for exactly one enable period at the middle of a bit. At most one vote sample can then be hit, wherever the window sits. Random frames also combine filter mode, an uncleared flag and a low stop bit. A directed back-to-back burst checks that reception restarts one bit time after the last shift.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_STOP = 2'd2
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nbr_vote.sv
module nbr_vote #(
    parameter int                CNT_W = 4,
    parameter logic [CNT_W-1:0]  PT_A  = 4'd7,
    parameter logic [CNT_W-1:0]  PT_B  = 4'd8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             bit_in,
    output logic             vote
);
    import nbr_pkg::*;

    typedef struct packed {
        logic s_a;
        logic s_b;
    } vote_regs_t;

    vote_regs_t v_d, v_q;

    always_comb begin
        v_d = v_q;
        if (sample_en && cnt == PT_A) v_d.s_a = bit_in;
        if (sample_en && cnt == PT_B) v_d.s_b = bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '{s_a: 1'b1, s_b: 1'b1};
        else        v_q <= v_d;
    end

    assign vote = maj3(v_q.s_a, v_q.s_b, bit_in);

    // R3
    samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(v_q));
endmodule

// File: rtl/nine_bit_rx.sv
module nine_bit_rx #(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_in,
    input  logic              filter_en,
    input  logic              rx_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_done
);
    import nbr_pkg::*;

    localparam int               CNT_W = $clog2(OVERSAMPLE);
    localparam int               SR_W  = DATA_W + 1;
    localparam logic [CNT_W-1:0] PT_A  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] PT_B  = CNT_W'(OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] PT_C  = CNT_W'(OVERSAMPLE / 2 + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [SR_W-1:0]   sr;
        logic              last;
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              done;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic rx_s;
    logic vote;
    logic [DATA_W-1:0] rev;
    logic [CNT_W-1:0]  cnt_inc;

    nbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    nbr_vote #(.CNT_W(CNT_W), .PT_A(PT_A), .PT_B(PT_B)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(sample_en),
        .cnt      (r_q.cnt),
        .bit_in   (rx_s),
        .vote     (vote)
    );

    // data bit 0 arrived first, so it sits just below the start bit
    always_comb begin
        for (int i = 0; i < DATA_W; i++) rev[i] = r_q.sr[DATA_W-1-i];
    end

    assign cnt_inc = (r_q.cnt == CNT_LAST) ? '0 : r_q.cnt + 1'b1;

    always_comb begin
        r_d = r_q;
        if (rx_clr) r_d.done = 1'b0;
        if (sample_en) begin
            r_d.last = rx_s;
            unique case (r_q.state)
                ST_IDLE: begin
                    if (r_q.last && !rx_s) begin
                        r_d.state = ST_DATA;
                        r_d.cnt   = '0;
                        r_d.sr    = '1;
                    end
                end
                ST_DATA: begin
                    r_d.cnt = cnt_inc;
                    if (r_q.cnt == PT_C) begin
                        if (!r_q.sr[SR_W-1]) begin
                            if (!r_q.done && (!filter_en || vote)) begin
                                r_d.data = rev;
                                r_d.bit9 = vote;
                                r_d.done = 1'b1;
                            end
                            r_d.state = ST_STOP;
                        end else if (&r_q.sr && vote) begin
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.sr = {r_q.sr[SR_W-2:0], vote};
                        end
                    end
                end
                ST_STOP: begin
                    r_d.cnt = cnt_inc;
                    if (r_q.cnt == PT_C) r_d.state = ST_IDLE;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.last  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_byte = r_q.data;
    assign rx_bit9 = r_q.bit9;
    assign rx_done = r_q.done;

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rx_clr |=> rx_done && $stable(rx_byte) && $stable(rx_bit9));
    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rx_clr |=> !rx_done);
    // R6
    filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> (!filter_en || rx_bit9));
    // R7
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> $rose(rx_done));
    // R4
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA) && sample_en && (r_q.cnt == PT_C) && (&r_q.sr) && vote
        |=> (r_q.state == ST_IDLE) && $stable(rx_done));
endmodule

// File: tb/nine_bit_rx_tb.sv
module nine_bit_rx_tb;
    localparam int BIT_CLKS = 32;  // 16 enables, one every two clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_en = 1'b0;
    logic rx_in = 1'b1;
    logic filter_en = 1'b0;
    logic rx_clr = 1'b0;
    logic [7:0] rx_byte;
    logic rx_bit9;
    logic rx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_byte = 8'h00;
    logic       exp_b9   = 1'b0;
    logic       exp_done = 1'b0;

    always #2 clk = ~clk;

    nine_bit_rx u_dut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_in(rx_in),
        .filter_en(filter_en), .rx_clr(rx_clr),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_done(rx_done)
    );

    initial begin
        forever begin
            @(negedge clk);
            sample_en = ~sample_en;
        end
    end

    function automatic bit accepts(input bit done, input bit sm, input bit b9);
        return !done && (!sm || b9);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        @(negedge clk);
        check({req, " byte"}, rx_byte, exp_byte);
        check({req, " bit9"}, rx_bit9, exp_b9);
        check({req, " done"}, rx_done, exp_done);
    endtask

    // glitch_idx: bit index 0..10 to disturb for one enable period mid-bit, -1 for none
    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop,
                              input int glitch_idx);
        logic [10:0] bits;
        bits = {stop, b9, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            rx_in = bits[i];
            if (i == glitch_idx) begin
                repeat (15) @(negedge clk);
                rx_in = ~bits[i];
                repeat (2) @(negedge clk);
                rx_in = bits[i];
                repeat (BIT_CLKS - 18) @(negedge clk);
            end else begin
                repeat (BIT_CLKS - 1) @(negedge clk);
            end
        end
        if (accepts(exp_done, filter_en, b9)) begin
            exp_byte = d;
            exp_b9   = b9;
            exp_done = 1'b1;
        end
    endtask

    task automatic idle_gap(input int nbits);
        @(negedge clk);
        rx_in = 1'b1;
        repeat (nbits * BIT_CLKS) @(negedge clk);
    endtask

    task automatic clear_done();
        @(negedge clk);
        rx_clr = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0;
        exp_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outputs("R1 reset");

        // R2 R5: plain frame
        send_frame(8'hA5, 1'b1, 1'b1, -1);
        idle_gap(1);
        check_outputs("R2 R5 basic");

        // R8: flag holds, then clears
        repeat (20) @(negedge clk);
        check("R8 hold", rx_done, 1);
        clear_done();
        check("R8 clear", rx_done, 0);

        // R7: second frame while flag set is dropped
        send_frame(8'h3C, 1'b0, 1'b1, -1);
        idle_gap(1);
        check_outputs("R7 accepted");
        send_frame(8'hFF, 1'b1, 1'b1, -1);
        idle_gap(1);
        check_outputs("R7 dropped");
        clear_done();

        // R6: filter drops ninth-bit-0 frame, keeps ninth-bit-1 frame
        filter_en = 1'b1;
        send_frame(8'h81, 1'b0, 1'b1, -1);
        idle_gap(1);
        check_outputs("R6 filtered");
        send_frame(8'h42, 1'b1, 1'b1, -1);
        idle_gap(1);
        check_outputs("R6 address");
        clear_done();
        filter_en = 1'b0;

        // R4: short low pulse is a false start, then a real frame follows
        @(negedge clk);
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLKS * 2) @(negedge clk);
        check_outputs("R4 false start");
        send_frame(8'h5A, 1'b0, 1'b1, -1);
        idle_gap(1);
        check_outputs("R4 recovery");
        clear_done();

        // R3: single-sample glitches in start and data bits
        send_frame(8'h0F, 1'b1, 1'b1, 0);
        idle_gap(1);
        check_outputs("R3 glitch start");
        clear_done();
        send_frame(8'hC3, 1'b0, 1'b1, 9);
        idle_gap(1);
        check_outputs("R3 glitch ninth");
        clear_done();

        // R9: low stop bit, then back-to-back frames
        send_frame(8'h96, 1'b1, 1'b0, -1);
        idle_gap(1);
        check_outputs("R9 low stop");
        clear_done();
        send_frame(8'h11, 1'b0, 1'b1, -1);
        check("R9 b2b first", rx_byte, 8'h11);
        clear_done();
        send_frame(8'h22, 1'b1, 1'b1, -1);
        idle_gap(1);
        check_outputs("R9 b2b second");
        clear_done();

        // random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] d;
            logic b9, st;
            int g;
            d  = 8'($urandom);
            b9 = 1'($urandom);
            st = ($urandom % 4) != 0;
            g  = ($urandom % 3 == 0) ? int'($urandom % 11) : -1;
            filter_en = ($urandom % 3) == 0;
            if ($urandom % 2 == 0) clear_done();
            send_frame(d, b9, st, g);
            idle_gap(1);
            check_outputs("R3 R5 R6 R7 R9 random");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule